// File: doc/BRIEF.md
# I2C Bit-Level Master Engine

This block is the bit-level part of an I2C master. A controller above it sends one command at a time: bus recovery, START, STOP, byte write, or byte read. The engine then moves the two open-drain lines through that command's sequence of timing slots. Every bit period is built from equal delay slots. A prescaler sets how many system clocks make one slot. The engine drives a line only to pull it low. A high level appears when the line is released and the pull-up takes over.

Commands arrive on a valid/ready handshake. Each command carries a 3-bit code, a byte to send, and an acknowledge-select bit for reads. While a command runs, the engine holds `cmd_ready` low. When `cmd_ready` rises again, `rd_data` and `ack_n` hold the results of the command that just finished. Clock stretching, arbitration between masters, and slave operation are not supported.

The recovery command frees a slave that is stuck holding SDA low. It releases SDA, pulses SCL nine times, and then ends with a complete STOP.

Top module: `i2c_bit_master`

## Requirements
- R1: After reset, and at once whenever reset is asserted during a command, `scl_oe` and `sda_oe` are 0 and `cmd_ready` is 1. While the engine is idle and no command is offered, neither enable changes.
- R2: `cmd_ready` goes low in the cycle after a command is accepted. It returns high exactly N×PRESCALE clocks after the accepting edge. N is 40 for recovery, 4 for START, 4 for STOP, 37 for write, 37 for read, and 1 for an undefined code.
- R3: Code 1 (START), issued on an idle bus, makes SDA fall exactly once while SCL is high. It produces no SCL rising edge and no STOP condition.
- R4: Code 2 (STOP) gives exactly one SCL rising edge. SDA then rises once while SCL is high. Afterwards both enables are 0.
- R5: Code 3 (write) presents `cmd_wdata` MSB first, one bit per SCL rising edge, over 8 clocks. SDA is released for a 9th clock. `ack_n` returns the SDA level sampled two slots into that clock's high phase: 0 means acknowledged, 1 means refused.
- R6: Code 4 (read) releases SDA for 8 SCL clocks. It returns in `rd_data`, MSB first, the SDA levels sampled one slot after each rising edge.
- R7: After the 8 read bits, the master gives a 9th clock. During it, SDA is pulled low when `cmd_ack_sel` is 0 (continue) and released when it is 1 (end of read). The SCL high phase of that clock lasts two slots.
- R8: Code 0 (recovery) releases SDA and gives 9 SCL pulses of two low slots and two high slots each. It then performs a STOP: 10 SCL rising edges in total, one STOP condition and no START.
- R9: During writes and reads, the master changes its SDA enable only while SCL is held low. These commands therefore never create a START or STOP condition.
- R10: Codes 5, 6 and 7 are accepted and finish after one slot. Neither line changes.
- R11: Holding `cmd_valid` high with another code while a command runs has no effect. The running command keeps its length and bus activity, and the stray code is not accepted.
- R12: An enable of 1 always pulls its line low. A high level comes only from releasing the line, so after a STOP both enables are 0 and both lines read high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | Engine idle; a command offered now is accepted at this edge |
| cmd_code | input | 3 | 0 recover, 1 START, 2 STOP, 3 write, 4 read, 5 to 7 no operation |
| cmd_wdata | input | 8 | Byte sent by a write, MSB first |
| cmd_ack_sel | input | 1 | Level driven in a read's 9th clock: 0 acknowledge, 1 refuse |
| rd_data | output | 8 | Byte captured by the last read |
| ack_n | output | 1 | SDA level sampled in the 9th clock of the last write |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | Sampled SCL level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA level |

## Verification
The hardest situation to reach from the ports is a read that follows a write with no STOP in between. At that point SCL is already low, so the read's first bit has no falling edge to which a slave could align its data. The bench's responder therefore tracks the bus itself. It counts SCL rising edges from the moment each command is issued and updates its SDA drive only while SCL is low. It drives per-byte acknowledges or refusals and per-byte read data. Stray command codes held during a busy write, and a reset asserted in the middle of a byte, are added as directed cases.

// File: rtl/i2cbm_pkg.sv
package i2cbm_pkg;

  typedef enum logic [2:0] {
    OP_RECOVER = 3'd0,
    OP_START   = 3'd1,
    OP_STOP    = 3'd2,
    OP_WRITE   = 3'd3,
    OP_READ    = 3'd4
  } op_e;

  localparam int DATA_W         = 8;
  localparam int RECOVER_PULSES = 9;
  localparam int SLOTS_PER_BIT  = 4;
  localparam int BIT_W          = $clog2(RECOVER_PULSES + 1);
  localparam int SLOT_W         = $clog2(SLOTS_PER_BIT + 1);

  // index of the final bit position of a command
  function automatic logic [BIT_W-1:0] final_bit(op_e op);
    case (op)
      OP_RECOVER:        return BIT_W'(RECOVER_PULSES);
      OP_WRITE, OP_READ: return BIT_W'(DATA_W);
      default:           return '0;
    endcase
  endfunction

  // index of the final slot inside one bit position
  function automatic logic [SLOT_W-1:0] final_slot(op_e op, logic [BIT_W-1:0] bitn);
    case (op)
      OP_RECOVER, OP_START, OP_STOP: return SLOT_W'(SLOTS_PER_BIT - 1);
      OP_WRITE, OP_READ:
        return (bitn == BIT_W'(DATA_W)) ? SLOT_W'(SLOTS_PER_BIT) : SLOT_W'(SLOTS_PER_BIT - 1);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/i2cbm_slot_timer.sv
module i2cbm_slot_timer #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)
      cnt_d = '0;
    else if (run)
      cnt_d = (cnt_q == CNT_MAX) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && !clear && (cnt_q == CNT_MAX);

  generate
    if (PRESCALE > 1) begin : g_gap
      // R2
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/i2cbm_shifter.sv
module i2cbm_shifter
  import i2cbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic              shift_out,
  input  logic              shift_in,
  input  logic              ack_sample,
  input  logic              sda_in,
  output logic              tx_bit,
  output logic [DATA_W-1:0] rdata,
  output logic              ack_n
);
  logic [DATA_W-1:0] sr_q, sr_d;
  logic              ack_q, ack_d;

  always_comb begin
    sr_d  = sr_q;
    ack_d = ack_q;
    if (load)
      sr_d = wdata;
    else if (shift_out)
      sr_d = {sr_q[DATA_W-2:0], 1'b0};
    else if (shift_in)
      sr_d = {sr_q[DATA_W-2:0], sda_in};
    if (ack_sample)
      ack_d = sda_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      ack_q <= 1'b1;
    end else begin
      sr_q  <= sr_d;
      ack_q <= ack_d;
    end
  end

  assign tx_bit = sr_q[DATA_W-1];
  assign rdata  = sr_q;
  assign ack_n  = ack_q;

  // R5
  shift_ctl_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load, shift_out, shift_in, ack_sample}));

endmodule

// File: rtl/i2cbm_sequencer.sv
module i2cbm_sequencer
  import i2cbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic [2:0] cmd_in,
  input  logic       ack_sel_in,
  input  logic       tick,
  input  logic       tx_bit,
  output logic       busy,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       load,
  output logic       shift_out,
  output logic       shift_in,
  output logic       ack_sample
);
  op_e               op_q, op_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              busy_q, busy_d;
  logic              ack_sel_q, ack_sel_d;
  logic              scl_q, scl_d, sda_q, sda_d;

  op_e               tgt_op;
  logic [BIT_W-1:0]  tgt_bit;
  logic [SLOT_W-1:0] tgt_slot;
  logic              tgt_valid;
  logic              at_last_slot, at_last_bit, step;
  logic              tgt_data_bit, tgt_stop_shape;

  // position advance
  always_comb begin
    op_d      = op_q;
    bit_d     = bit_q;
    slot_d    = slot_q;
    busy_d    = busy_q;
    ack_sel_d = ack_sel_q;
    tgt_valid = 1'b0;
    step         = busy_q && tick;
    at_last_slot = (slot_q == final_slot(op_q, bit_q));
    at_last_bit  = (bit_q == final_bit(op_q));
    if (accept) begin
      busy_d    = 1'b1;
      op_d      = op_e'(cmd_in);
      ack_sel_d = ack_sel_in;
      bit_d     = '0;
      slot_d    = '0;
      tgt_valid = 1'b1;
    end else if (step) begin
      if (at_last_slot) begin
        if (at_last_bit) begin
          busy_d = 1'b0;
        end else begin
          bit_d     = bit_q + 1'b1;
          slot_d    = '0;
          tgt_valid = 1'b1;
        end
      end else begin
        slot_d    = slot_q + 1'b1;
        tgt_valid = 1'b1;
      end
    end
    tgt_op   = op_d;
    tgt_bit  = bit_d;
    tgt_slot = slot_d;
  end

  // line actions applied on entry to a slot
  always_comb begin
    scl_d = scl_q;
    sda_d = sda_q;
    tgt_data_bit   = (tgt_bit < BIT_W'(DATA_W));
    tgt_stop_shape = (tgt_op == OP_STOP) ||
                     (tgt_op == OP_RECOVER && tgt_bit == BIT_W'(RECOVER_PULSES));
    if (tgt_valid) begin
      if (tgt_stop_shape) begin
        case (tgt_slot)
          SLOT_W'(0): scl_d = 1'b1;
          SLOT_W'(1): sda_d = 1'b1;
          SLOT_W'(2): scl_d = 1'b0;
          SLOT_W'(3): sda_d = 1'b0;
          default: ;
        endcase
      end else begin
        case (tgt_op)
          OP_RECOVER: begin
            case (tgt_slot)
              SLOT_W'(0): scl_d = 1'b1;
              SLOT_W'(1): sda_d = 1'b0;
              SLOT_W'(2): scl_d = 1'b0;
              default: ;
            endcase
          end
          OP_START: begin
            case (tgt_slot)
              SLOT_W'(1): sda_d = 1'b0;
              SLOT_W'(2): scl_d = 1'b0;
              SLOT_W'(3): sda_d = 1'b1;
              default: ;
            endcase
          end
          OP_WRITE, OP_READ: begin
            case (tgt_slot)
              SLOT_W'(0): scl_d = 1'b1;
              SLOT_W'(1): begin
                if (tgt_data_bit)
                  sda_d = (tgt_op == OP_WRITE) ? !tx_bit : 1'b0;
                else
                  sda_d = (tgt_op == OP_WRITE) ? 1'b0 : !ack_sel_d;
              end
              SLOT_W'(2): scl_d = 1'b0;
              SLOT_W'(4): scl_d = 1'b1;
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= OP_RECOVER;
      bit_q     <= '0;
      slot_q    <= '0;
      busy_q    <= 1'b0;
      ack_sel_q <= 1'b0;
      scl_q     <= 1'b0;
      sda_q     <= 1'b0;
    end else begin
      op_q      <= op_d;
      bit_q     <= bit_d;
      slot_q    <= slot_d;
      busy_q    <= busy_d;
      ack_sel_q <= ack_sel_d;
      scl_q     <= scl_d;
      sda_q     <= sda_d;
    end
  end

  // shift and sample strobes at the end of a slot
  assign load       = accept && (op_e'(cmd_in) == OP_WRITE);
  assign shift_out  = step && op_q == OP_WRITE && bit_q < BIT_W'(DATA_W) && slot_q == SLOT_W'(3);
  assign ack_sample = step && op_q == OP_WRITE && bit_q == BIT_W'(DATA_W) && slot_q == SLOT_W'(3);
  assign shift_in   = step && op_q == OP_READ && bit_q < BIT_W'(DATA_W) && slot_q == SLOT_W'(2);

  assign busy   = busy_q;
  assign scl_oe = scl_q;
  assign sda_oe = sda_q;

  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !tick && !accept |=> $stable(slot_q) && $stable(bit_q));

  // R9
  sda_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_q && $past(!scl_q) && (sda_q != $past(sda_q))) |->
      ((slot_q == SLOT_W'(3) && (op_q == OP_START || op_q == OP_STOP ||
         (op_q == OP_RECOVER && bit_q == BIT_W'(RECOVER_PULSES)))) ||
       (op_q == OP_START && slot_q == SLOT_W'(1))));

  // R8
  recover_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && op_q == OP_RECOVER && bit_q < BIT_W'(RECOVER_PULSES) &&
      slot_q >= SLOT_W'(2) |-> !sda_q);

endmodule

// File: rtl/i2c_bit_master.sv
module i2c_bit_master
  import i2cbm_pkg::*;
#(
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_code,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_ack_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic              ack_n,
  output logic              scl_oe,
  input  logic              scl_in,
  output logic              sda_oe,
  input  logic              sda_in
);
  logic [1:0] rst_pipe_q;
  logic       rst_n_i;
  logic       busy, accept, tick;
  logic       tx_bit, load, shift_out, shift_in, ack_sample;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_i = rst_pipe_q[1];

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && !busy;

  i2cbm_slot_timer #(.PRESCALE(PRESCALE)) u_timer (
    .clk   (clk),
    .rst_n (rst_n_i),
    .clear (accept),
    .run   (busy),
    .tick  (tick)
  );

  i2cbm_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .accept     (accept),
    .cmd_in     (cmd_code),
    .ack_sel_in (cmd_ack_sel),
    .tick       (tick),
    .tx_bit     (tx_bit),
    .busy       (busy),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .load       (load),
    .shift_out  (shift_out),
    .shift_in   (shift_in),
    .ack_sample (ack_sample)
  );

  i2cbm_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .load       (load),
    .wdata      (cmd_wdata),
    .shift_out  (shift_out),
    .shift_in   (shift_in),
    .ack_sample (ack_sample),
    .sda_in     (sda_in),
    .tx_bit     (tx_bit),
    .rdata      (rd_data),
    .ack_n      (ack_n)
  );

  // R2
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    cmd_valid && cmd_ready |=> !cmd_ready);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    cmd_ready && !cmd_valid |=> $stable(scl_oe) && $stable(sda_oe));

  // R12
  drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    scl_oe |-> !scl_in);

endmodule

// File: tb/tb_i2c_bit_master.sv
module tb_i2c_bit_master;
  localparam int CLK_PERIOD = 10;
  localparam int PRESCALE   = 3;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       cmd_valid, cmd_ready, cmd_ack_sel, ack_n;
  logic [2:0] cmd_code;
  logic [7:0] cmd_wdata, rd_data;
  logic       scl_oe, sda_oe;
  logic       slave_pull;
  wire        scl_bus = ~scl_oe;
  wire        sda_bus = ~(sda_oe | slave_pull);

  i2c_bit_master #(.PRESCALE(PRESCALE)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_wdata(cmd_wdata), .cmd_ack_sel(cmd_ack_sel),
    .rd_data(rd_data), .ack_n(ack_n), .scl_oe(scl_oe), .scl_in(scl_bus),
    .sda_oe(sda_oe), .sda_in(sda_bus)
  );

  // bus monitor
  logic       mon_on = 1'b0;
  int         rises = 0, starts = 0, stops = 0;
  logic [8:0] cap = '0;
  always @(posedge scl_bus) if (mon_on) begin
    rises <= rises + 1;
    cap   <= {cap[7:0], sda_bus};
  end
  always @(negedge sda_bus) if (mon_on && scl_bus === 1'b1) starts <= starts + 1;
  always @(posedge sda_bus) if (mon_on && scl_bus === 1'b1) stops  <= stops + 1;

  // responder: updates its drive only while SCL is low
  logic       resp_on = 1'b0, resp_rd = 1'b0, resp_ack = 1'b0;
  logic [7:0] resp_byte = '0;
  int         base_rises = 0, idx = 0;
  always @(scl_bus or rises or base_rises) if (scl_bus == 1'b0) idx = rises - base_rises;
  always_comb slave_pull = resp_on && (resp_rd ? (idx < 8 && !resp_byte[3'(7 - idx)])
                                               : (resp_ack && idx == 8));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] wdata;
    logic       ack_sel;
    logic       rack;
    logic [7:0] rbyte;
    logic [7:0] slots;
    logic [3:0] nrise;
    logic [1:0] nstart;
    logic [1:0] nstop;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'h00, 1'b0, 1'b0, 8'h00, 8'd40, 4'd10, 2'd0, 2'd1},  // recover
    '{3'd1, 8'h00, 1'b0, 1'b0, 8'h00, 8'd4,  4'd0,  2'd1, 2'd0},  // start
    '{3'd3, 8'hA5, 1'b0, 1'b1, 8'h00, 8'd37, 4'd9,  2'd0, 2'd0},  // write, acked
    '{3'd3, 8'h3C, 1'b0, 1'b0, 8'h00, 8'd37, 4'd9,  2'd0, 2'd0},  // write, refused
    '{3'd4, 8'h00, 1'b0, 1'b0, 8'h96, 8'd37, 4'd9,  2'd0, 2'd0},  // read, master acks
    '{3'd4, 8'h00, 1'b1, 1'b0, 8'h5A, 8'd37, 4'd9,  2'd0, 2'd0},  // read, master refuses
    '{3'd2, 8'h00, 1'b0, 1'b0, 8'h00, 8'd4,  4'd1,  2'd0, 2'd1},  // stop
    '{3'd1, 8'h00, 1'b0, 1'b0, 8'h00, 8'd4,  4'd0,  2'd1, 2'd0},
    '{3'd3, 8'hFF, 1'b0, 1'b1, 8'h00, 8'd37, 4'd9,  2'd0, 2'd0},
    '{3'd3, 8'h00, 1'b0, 1'b1, 8'h00, 8'd37, 4'd9,  2'd0, 2'd0},
    '{3'd4, 8'h00, 1'b1, 1'b0, 8'h01, 8'd37, 4'd9,  2'd0, 2'd0},
    '{3'd2, 8'h00, 1'b0, 1'b0, 8'h00, 8'd4,  4'd1,  2'd0, 2'd1},
    '{3'd6, 8'h00, 1'b0, 1'b0, 8'h00, 8'd1,  4'd0,  2'd0, 2'd0}   // undefined code
  };

  int r0, s0, p0, cyc;

  task automatic run_cmd(input vec_t v, input int spur);
    @(negedge clk);
    r0 = rises; s0 = starts; p0 = stops;
    base_rises = rises;
    resp_on   = (v.op == 3'd3) || (v.op == 3'd4);
    resp_rd   = (v.op == 3'd4);
    resp_ack  = v.rack;
    resp_byte = v.rbyte;
    cmd_code  = v.op; cmd_wdata = v.wdata; cmd_ack_sel = v.ack_sel;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cyc = 0;
    cmd_valid = (spur > 0);
    if (spur > 0) cmd_code = 3'd2;
    while (!cmd_ready && cyc < 2000) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (cyc >= spur) cmd_valid = 1'b0;
    end
    cmd_valid = 1'b0;
  endtask

  task automatic check_vec(input vec_t v);
    chk("R2 duration", cyc, int'(v.slots) * PRESCALE);
    chk((v.op == 3'd0) ? "R8 scl rises" : "R2 scl rises", rises - r0, int'(v.nrise));
    chk((v.op == 3'd1) ? "R3 start count" : "R9 start count", starts - s0, int'(v.nstart));
    chk((v.op == 3'd2 || v.op == 3'd0) ? "R4 stop count" : "R9 stop count", stops - p0, int'(v.nstop));
    if (v.op == 3'd3) begin
      chk("R5 byte on bus", int'(cap[8:1]), int'(v.wdata));
      chk("R5 ninth bit level", int'(cap[0]), int'(!v.rack));
      chk("R5 ack_n", int'(ack_n), int'(!v.rack));
    end
    if (v.op == 3'd4) begin
      chk("R6 rd_data", int'(rd_data), int'(v.rbyte));
      chk("R6 bus byte", int'(cap[8:1]), int'(v.rbyte));
      chk("R7 master ack level", int'(cap[0]), int'(v.ack_sel));
    end
    if (v.op == 3'd2 || v.op == 3'd0) begin
      chk("R12 scl released", int'(scl_oe), 0);
      chk("R12 sda released", int'(sda_oe), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    vec_t w;
    logic so, da;
    cmd_valid = 1'b0; cmd_code = '0; cmd_wdata = '0; cmd_ack_sel = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 ready after reset", int'(cmd_ready), 1);
    chk("R1 scl_oe after reset", int'(scl_oe), 0);
    chk("R1 sda_oe after reset", int'(sda_oe), 0);
    mon_on = 1'b1;

    for (int i = 0; i < NV; i++) begin
      so = scl_oe; da = sda_oe;
      run_cmd(VECS[i], 0);
      check_vec(VECS[i]);
      if (VECS[i].op > 3'd4) begin
        // R10 undefined code leaves lines alone
        chk("R10 scl unchanged", int'(scl_oe), int'(so));
        chk("R10 sda unchanged", int'(sda_oe), int'(da));
      end
    end

    // R1 idle: lines hold with nothing offered
    so = scl_oe; da = sda_oe;
    repeat (10) @(negedge clk);
    chk("R1 idle scl hold", int'(scl_oe), int'(so));
    chk("R1 idle sda hold", int'(sda_oe), int'(da));

    // R11 stray code held while a write is busy
    run_cmd(VECS[1], 0);
    w = VECS[2]; w.wdata = 8'h81;
    run_cmd(w, 20);
    chk("R11 duration unchanged", cyc, 37 * PRESCALE);
    chk("R11 rises unchanged", rises - r0, 9);
    chk("R11 no stop emitted", stops - p0, 0);
    chk("R11 byte on bus", int'(cap[8:1]), 8'h81);
    repeat (3) @(negedge clk);
    chk("R11 not accepted later", int'(cmd_ready), 1);
    run_cmd(VECS[11], 0);
    check_vec(VECS[11]);

    // R1 reset in the middle of a byte
    run_cmd(VECS[1], 0);
    @(negedge clk);
    resp_on = 1'b1; resp_rd = 1'b0; resp_ack = 1'b1; base_rises = rises;
    cmd_code = 3'd3; cmd_wdata = 8'h00; cmd_valid = 1'b1;
    @(negedge clk) cmd_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk("R1 busy before reset", int'(cmd_ready), 0);
    rst_n = 1'b0;
    #1;
    chk("R1 mid-command scl_oe", int'(scl_oe), 0);
    chk("R1 mid-command sda_oe", int'(sda_oe), 0);
    chk("R1 mid-command ready", int'(cmd_ready), 1);
    resp_on = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule